// File: doc/BRIEF.md
# Shadow Register Synchronizer

This block sits between a fast bus clock domain and a slow always-on domain clocked at about 32 kHz. Software writes land at once in bus-side shadow copies. Each write is then carried into the slow-domain registers on a slow-clock edge, using a toggle request and acknowledge handshake through synchronizer flops. The held data stays frozen while a transfer is in flight. Two pending flags, one per register group, tell software when every write has landed.

The registers fall into two groups. The first group holds the counter and compare words. The second group holds the scratch words and the control word, and it also carries two commands. The first command clears the interrupt status; the clear reaches the interrupt line only when the slow domain applies it. The second command copies the slow-domain interrupt status back into the bus-side view. The transfer of counter and compare writes waits until a sync-enable bit in the control shadow is set.

Top module: `shadow_sync`

## Requirements
- R1: After reset, both pending flags, every synchronized register, the bus-side status view and the interrupt line are 0.
- R2: A write to a mapped register sets its group's pending flag in the next bus cycle. Group 0 (pend[0]) holds 0x08, 0x0C, 0x10, 0x20 and 0x24. Group 1 (pend[1]) holds scratch 0x30 to 0x4C, control 0x50, a status clear (0x58 with data bit 0 set) and a reload (0x68 with data bit 31 set).
- R3: A single write reaches `sync_regs` and its pending flag returns to 0 within 6 slow-clock periods. Register k sits at bits k*32+31:k*32. The register order is 0x08→0, 0x0C→1, 0x10→2, 0x20→3, 0x24→4, 0x30+4j→5+j (j=0..7), 0x50→13.
- R4: A new write to a register whose transfer is outstanding replaces the shadow value. The pending flag stays 1 until that last value is visible in `sync_regs`.
- R5: While bit 21 of the control shadow (0x50) is 0, group-0 writes stay pending and leave `sync_regs` unchanged. Setting the bit releases them.
- R6: Writes to unmapped addresses are ignored. So are writes to 0x58 without bit 0 and writes to 0x68 without bit 31. None of these sets a pending flag or changes a synchronized register.
- R7: An alarm event raises `irq_line` at the next slow edge. A status clear zeroes `bus_irq_stat` in the next bus cycle, but `irq_line` stays high until the clear has been transferred.
- R8: `bus_irq_stat` changes only through a clear or a reload. After a reload lands, it equals the slow-domain status.
- R9: The groups transfer independently: a group-1 write completes while group 0 is held by R5.
- R10: The held transfer data of a group does not change while that group's transfer is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| b_clk | input | 1 | Bus clock |
| b_rst | input | 1 | Synchronous active-high reset, bus domain |
| b_wr | input | 1 | Write strobe |
| b_addr | input | 7 | Byte offset of the write |
| b_wdata | input | 32 | Write data |
| s_clk | input | 1 | Slow always-on clock |
| s_rst | input | 1 | Synchronous active-high reset, slow domain |
| s_alarm | input | 1 | Alarm event in the slow domain, one slow cycle |
| sync_regs | output | 448 | Slow-domain register values, 14 words of 32 bits |
| pend | output | 2 | Per-group transfer pending flags |
| bus_irq_stat | output | 1 | Bus-side view of the interrupt status |
| irq_line | output | 1 | Interrupt line from the slow domain |

## Verification
A lost dirty bit or a stuck busy flag shows up on `pend` within a few bus cycles. The flag either drops before `sync_regs` holds the last written value, or it never drops within the 6-slow-period bound. Hold data that is corrupted mid-transfer shows up as a wrong word in `sync_regs` after the next slow edge. A mishandled clear or reload command shows up as `irq_line` and `bus_irq_stat` disagreeing with the order of events once the pending flag has cleared.

// File: rtl/shsync_pkg.sv
package shsync_pkg;
    localparam int DW       = 32;
    localparam int AW       = 7;
    localparam int NREG     = 14;
    localparam int NGRP     = 2;
    localparam int IDX_W    = $clog2(NREG);
    localparam int G0_LAST  = 4;
    localparam int G1_FIRST = G0_LAST + 1;
    localparam int G1_LAST  = NREG - 1;
    localparam int CTRL_IDX = NREG - 1;
    localparam int EN_BIT   = 21;
    localparam int CLR_BIT  = 0;
    localparam int RLD_BIT  = 31;

    typedef enum logic [1:0] {OP_NONE, OP_REG, OP_CLR, OP_RELOAD} op_e;

    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic int grp_of(input int i);
        return (i > G0_LAST) ? 1 : 0;
    endfunction

    function automatic dec_t decode_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        dec_t r;
        logic [AW-1:0] off;
        r.op  = OP_NONE;
        r.idx = '0;
        off   = a - 7'h30;
        case (a)
            7'h08: begin r.op = OP_REG; r.idx = IDX_W'(0); end
            7'h0C: begin r.op = OP_REG; r.idx = IDX_W'(1); end
            7'h10: begin r.op = OP_REG; r.idx = IDX_W'(2); end
            7'h20: begin r.op = OP_REG; r.idx = IDX_W'(3); end
            7'h24: begin r.op = OP_REG; r.idx = IDX_W'(4); end
            7'h50: begin r.op = OP_REG; r.idx = IDX_W'(CTRL_IDX); end
            7'h58: if (d[CLR_BIT]) r.op = OP_CLR;
            7'h68: if (d[RLD_BIT]) r.op = OP_RELOAD;
            default: begin
                if (a >= 7'h30 && a <= 7'h4C && a[1:0] == 2'b00) begin
                    r.op  = OP_REG;
                    r.idx = IDX_W'(G1_FIRST) + IDX_W'(off[AW-1:2]);
                end
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/shsync_sync.sv
module shsync_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/shsync_bus.sv
module shsync_bus
    import shsync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    input  logic [NGRP-1:0]           ack_tgl,
    input  logic                      back_stat,
    output logic [NGRP-1:0]           req_tgl,
    output logic [NREG-1:0][DW-1:0]   hold,
    output logic                      hold_clr,
    output logic                      hold_reload,
    output logic [NGRP-1:0]           busy,
    output logic [NGRP-1:0]           pend,
    output logic                      bview
);
    logic [NREG-1:0][DW-1:0] shadow;
    logic [NREG-1:0]         dirty;
    logic                    cmd_clr, cmd_reload;
    logic [NGRP-1:0]         ack_s, ack_d, ack_evt;
    logic [NGRP-1:0]         grp_dirty, launch;
    logic                    sync_en;
    dec_t                    dec;

    for (genvar g = 0; g < NGRP; g++) begin : g_ack
        shsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .d(ack_tgl[g]), .q(ack_s[g])
        );
    end

    assign ack_evt = ack_s ^ ack_d;
    assign sync_en = shadow[CTRL_IDX][EN_BIT];
    assign dec     = decode_wr(addr, wdata);

    always_comb begin
        grp_dirty = '0;
        for (int i = 0; i < NREG; i++) begin
            if (dirty[i]) grp_dirty[grp_of(i)] = 1'b1;
        end
        grp_dirty[1] = grp_dirty[1] | cmd_clr | cmd_reload;
        for (int g = 0; g < NGRP; g++) begin
            launch[g] = !busy[g] && grp_dirty[g] && (g != 0 || sync_en);
        end
    end

    assign pend = busy | grp_dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow      <= '0;
            dirty       <= '0;
            hold        <= '0;
            hold_clr    <= 1'b0;
            hold_reload <= 1'b0;
            cmd_clr     <= 1'b0;
            cmd_reload  <= 1'b0;
            busy        <= '0;
            req_tgl     <= '0;
            ack_d       <= '0;
            bview       <= 1'b0;
        end else begin
            ack_d <= ack_s;
            for (int g = 0; g < NGRP; g++) begin
                if (launch[g]) begin
                    busy[g]    <= 1'b1;
                    req_tgl[g] <= ~req_tgl[g];
                end else if (ack_evt[g]) begin
                    busy[g] <= 1'b0;
                end
            end
            for (int i = 0; i < NREG; i++) begin
                if (launch[grp_of(i)]) begin
                    hold[i]  <= shadow[i];
                    dirty[i] <= 1'b0;
                end
            end
            if (launch[1]) begin
                hold_clr    <= cmd_clr;
                hold_reload <= cmd_reload;
                cmd_clr     <= 1'b0;
                cmd_reload  <= 1'b0;
            end
            if (ack_evt[1] && hold_reload) bview <= back_stat;
            if (wr) begin
                case (dec.op)
                    OP_REG: begin
                        shadow[dec.idx] <= wdata;
                        dirty[dec.idx]  <= 1'b1;
                    end
                    OP_CLR: begin
                        cmd_clr <= 1'b1;
                        bview   <= 1'b0;
                    end
                    OP_RELOAD: cmd_reload <= 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/shsync_slow.sv
module shsync_slow
    import shsync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NGRP-1:0]         req_tgl,
    input  logic [NREG-1:0][DW-1:0] hold,
    input  logic                    hold_clr,
    input  logic                    hold_reload,
    input  logic                    alarm,
    output logic [NGRP-1:0]         ack_tgl,
    output logic [NREG-1:0][DW-1:0] regs,
    output logic                    stat,
    output logic                    back_stat
);
    logic [NGRP-1:0] req_s, req_d, apply;
    logic            stat_nxt;

    for (genvar g = 0; g < NGRP; g++) begin : g_req
        shsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .d(req_tgl[g]), .q(req_s[g])
        );
    end

    assign apply = req_s ^ req_d;

    always_comb begin
        if (alarm)                   stat_nxt = 1'b1;
        else if (apply[1] && hold_clr) stat_nxt = 1'b0;
        else                         stat_nxt = stat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d     <= '0;
            ack_tgl   <= '0;
            regs      <= '0;
            stat      <= 1'b0;
            back_stat <= 1'b0;
        end else begin
            req_d <= req_s;
            stat  <= stat_nxt;
            for (int g = 0; g < NGRP; g++) begin
                if (apply[g]) ack_tgl[g] <= ~ack_tgl[g];
            end
            for (int i = 0; i < NREG; i++) begin
                if (apply[grp_of(i)]) regs[i] <= hold[i];
            end
            if (apply[1] && hold_reload) back_stat <= stat_nxt;
        end
    end
endmodule

// File: rtl/shadow_sync.sv
module shadow_sync
    import shsync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               b_clk,
    input  logic               b_rst,
    input  logic               b_wr,
    input  logic [AW-1:0]      b_addr,
    input  logic [DW-1:0]      b_wdata,
    input  logic               s_clk,
    input  logic               s_rst,
    input  logic               s_alarm,
    output logic [NREG*DW-1:0] sync_regs,
    output logic [NGRP-1:0]    pend,
    output logic               bus_irq_stat,
    output logic               irq_line
);
    logic [NGRP-1:0]         req_tgl, ack_tgl, busy;
    logic [NREG-1:0][DW-1:0] hold, s_regs;
    logic                    hold_clr, hold_reload, back_stat;

    shsync_bus #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
        .clk(b_clk), .rst(b_rst), .wr(b_wr), .addr(b_addr), .wdata(b_wdata),
        .ack_tgl(ack_tgl), .back_stat(back_stat), .req_tgl(req_tgl),
        .hold(hold), .hold_clr(hold_clr), .hold_reload(hold_reload),
        .busy(busy), .pend(pend), .bview(bus_irq_stat)
    );

    shsync_slow #(.SYNC_STAGES(SYNC_STAGES)) u_slow (
        .clk(s_clk), .rst(s_rst), .req_tgl(req_tgl), .hold(hold),
        .hold_clr(hold_clr), .hold_reload(hold_reload), .alarm(s_alarm),
        .ack_tgl(ack_tgl), .regs(s_regs), .stat(irq_line), .back_stat(back_stat)
    );

    assign sync_regs = s_regs;
endmodule

// File: rtl/shsync_chk.sv
module shsync_chk
    import shsync_pkg::*;
(
    input logic                    b_clk,
    input logic                    b_rst,
    input logic                    b_wr,
    input logic [AW-1:0]           b_addr,
    input logic [DW-1:0]           b_wdata,
    input logic [NGRP-1:0]         pend,
    input logic [NGRP-1:0]         busy,
    input logic [NREG-1:0][DW-1:0] hold
);
    dec_t d;
    logic wr_g0, wr_g1;
    assign d     = decode_wr(b_addr, b_wdata);
    assign wr_g0 = b_wr && d.op == OP_REG && int'(d.idx) <= G0_LAST;
    assign wr_g1 = b_wr && d.op != OP_NONE && !(d.op == OP_REG && int'(d.idx) <= G0_LAST);

    AST_RESET_IDLE: assert property (@(posedge b_clk) disable iff (b_rst)
        $fell(b_rst) |-> pend == '0); // R1

    AST_WRITE_PENDS_G0: assert property (@(posedge b_clk) disable iff (b_rst)
        wr_g0 |=> pend[0]); // R2

    AST_WRITE_PENDS_G1: assert property (@(posedge b_clk) disable iff (b_rst)
        wr_g1 |=> pend[1]); // R2

    AST_UNMAPPED_QUIET: assert property (@(posedge b_clk) disable iff (b_rst)
        (b_wr && d.op == OP_NONE && pend == '0) |=> pend == '0); // R6

    AST_HOLD_STABLE_G0: assert property (@(posedge b_clk) disable iff (b_rst)
        (busy[0] && $past(busy[0])) |-> $stable(hold[G0_LAST:0])); // R10

    AST_HOLD_STABLE_G1: assert property (@(posedge b_clk) disable iff (b_rst)
        (busy[1] && $past(busy[1])) |-> $stable(hold[G1_LAST:G1_FIRST])); // R10
endmodule

bind shadow_sync shsync_chk u_chk (
    .b_clk(b_clk), .b_rst(b_rst), .b_wr(b_wr), .b_addr(b_addr),
    .b_wdata(b_wdata), .pend(pend), .busy(busy), .hold(hold)
);

// File: tb/tb_shadow_sync.sv
module tb_shadow_sync;
    import shsync_pkg::*;

    localparam int BCLK_PERIOD = 10;
    localparam int SCLK_PERIOD = 74;
    localparam int IDLE_LIMIT  = 6 * SCLK_PERIOD / BCLK_PERIOD;
    localparam int LONG_LIMIT  = 4 * IDLE_LIMIT;
    localparam int NV = 8;
    localparam logic [AW-1:0] V_ADDR [NV] = '{7'h08, 7'h0C, 7'h10, 7'h20, 7'h24, 7'h30, 7'h4C, 7'h3C};
    localparam logic [DW-1:0] V_DATA [NV] = '{32'hDEAD0001, 32'h0000BEEF, 32'h7FFF_FFFF, 32'h12345678,
                                             32'h00000AAA, 32'hCAFEF00D, 32'h80000001, 32'h55AA55AA};
    localparam int V_IDX [NV] = '{0, 1, 2, 3, 4, 5, 12, 8};

    logic b_clk = 1'b0, s_clk = 1'b0;
    logic b_rst, s_rst, b_wr, s_alarm;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wdata;
    logic [NREG*DW-1:0] sync_regs;
    logic [NGRP-1:0] pend;
    logic bus_irq_stat, irq_line;
    int checks = 0, failures = 0;

    shadow_sync dut (
        .b_clk(b_clk), .b_rst(b_rst), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .s_clk(s_clk), .s_rst(s_rst), .s_alarm(s_alarm), .sync_regs(sync_regs),
        .pend(pend), .bus_irq_stat(bus_irq_stat), .irq_line(irq_line)
    );

    always #(BCLK_PERIOD/2) b_clk = ~b_clk;
    always #(SCLK_PERIOD/2) s_clk = ~s_clk;

    function automatic logic [DW-1:0] reg_at(input int k);
        return sync_regs[k*DW +: DW];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge b_clk);
        b_wr = 1'b1; b_addr = a; b_wdata = d;
        @(negedge b_clk);
        b_wr = 1'b0;
    endtask

    task automatic wait_clear(input logic [1:0] mask, input int limit, output int n);
        n = 0;
        while ((pend & mask) != 2'b00 && n < limit) begin
            @(negedge b_clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge b_clk);
        checks++; failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        logic [NREG*DW-1:0] snap;
        b_rst = 1'b1; s_rst = 1'b1; b_wr = 1'b0; b_addr = '0; b_wdata = '0; s_alarm = 1'b0;
        repeat (3) @(negedge s_clk);
        @(negedge b_clk);
        b_rst = 1'b0; s_rst = 1'b0;
        @(negedge b_clk);

        // R1 reset state
        chk("R1 pend", 64'(pend), 64'd0);
        chk("R1 regs", 64'(sync_regs == '0), 64'd1);
        chk("R1 bus_irq_stat", 64'(bus_irq_stat), 64'd0);
        chk("R1 irq_line", 64'(irq_line), 64'd0);

        // R5 group 0 held while sync enable is 0
        bus_write(7'h08, 32'h00001111);
        chk("R2 pend0 set", 64'(pend), 64'd1);
        repeat (8 * SCLK_PERIOD / BCLK_PERIOD) @(negedge b_clk);
        chk("R5 held pending", 64'(pend[0]), 64'd1);
        chk("R5 reg unchanged", 64'(reg_at(0)), 64'd0);
        // R9 group 1 completes while group 0 is held
        bus_write(7'h30, 32'h0000ABCD);
        wait_clear(2'b10, IDLE_LIMIT, n);
        chk("R9 g1 landed", 64'(reg_at(5)), 64'h0000ABCD);
        chk("R9 g0 still pending", 64'(pend[0]), 64'd1);
        bus_write(7'h50, 32'h1 << EN_BIT);
        wait_clear(2'b11, LONG_LIMIT, n);
        chk("R5 released", 64'(reg_at(0)), 64'h00001111);
        chk("R5 ctrl synced", 64'(reg_at(13)), 64'(32'h1 << EN_BIT));

        // R2 / R3 vector walk
        for (int v = 0; v < NV; v++) begin
            bus_write(V_ADDR[v], V_DATA[v]);
            chk("R2 group flag", 64'(pend), (V_IDX[v] > G0_LAST) ? 64'd2 : 64'd1);
            wait_clear(2'b11, LONG_LIMIT, n);
            chk("R3 latency bound", 64'(n <= IDLE_LIMIT), 64'd1);
            chk("R3 value", 64'(reg_at(V_IDX[v])), 64'(V_DATA[v]));
        end

        // R6 ignored writes
        snap = sync_regs;
        bus_write(7'h00, 32'hFFFFFFFF);
        chk("R6 unmapped pend", 64'(pend), 64'd0);
        bus_write(7'h58, 32'hFFFFFFFE);
        chk("R6 clr w/o bit0 pend", 64'(pend), 64'd0);
        bus_write(7'h68, 32'h7FFFFFFF);
        chk("R6 reload w/o bit31 pend", 64'(pend), 64'd0);
        bus_write(7'h32, 32'h12121212);
        repeat (4 * SCLK_PERIOD / BCLK_PERIOD) @(negedge b_clk);
        chk("R6 regs unchanged", 64'(sync_regs == snap), 64'd1);
        chk("R6 pend idle", 64'(pend), 64'd0);

        // R4 back-to-back rewrite
        bus_write(7'h10, 32'hAAAA0000);
        bus_write(7'h10, 32'hBBBB1111);
        wait_clear(2'b01, LONG_LIMIT, n);
        chk("R4 last value b2b", 64'(reg_at(2)), 64'hBBBB1111);
        // R4 rewrite in mid-transfer
        bus_write(7'h20, 32'h0000C0DE);
        repeat (2 * SCLK_PERIOD / BCLK_PERIOD) @(negedge b_clk);
        bus_write(7'h20, 32'h0000F00D);
        wait_clear(2'b01, LONG_LIMIT, n);
        chk("R4 last value mid", 64'(reg_at(3)), 64'h0000F00D);

        // R7 / R8 interrupt path
        @(negedge s_clk); s_alarm = 1'b1;
        @(negedge s_clk); s_alarm = 1'b0;
        chk("R7 irq raised", 64'(irq_line), 64'd1);
        chk("R8 view untouched by event", 64'(bus_irq_stat), 64'd0);
        bus_write(7'h68, 32'h80000000);
        chk("R2 reload pends g1", 64'(pend), 64'd2);
        wait_clear(2'b10, LONG_LIMIT, n);
        @(negedge b_clk);
        chk("R8 reload view", 64'(bus_irq_stat), 64'd1);
        bus_write(7'h58, 32'h00000001);
        chk("R7 view cleared", 64'(bus_irq_stat), 64'd0);
        chk("R7 line still high", 64'(irq_line), 64'd1);
        chk("R2 clear pends g1", 64'(pend), 64'd2);
        wait_clear(2'b10, LONG_LIMIT, n);
        chk("R7 line dropped", 64'(irq_line), 64'd0);
        bus_write(7'h68, 32'h80000000);
        wait_clear(2'b10, LONG_LIMIT, n);
        @(negedge b_clk);
        chk("R8 reload after clear", 64'(bus_irq_stat), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule